// File: doc/BRIEF.md
# PCI Interrupt Router with Legacy Wiring Detection

This block folds the four interrupt pins (INTA..INTD) of each PCI slot onto four level-sensitive system interrupt lines. Each slot's pins are rotated by an amount derived from the slot number, and a board-variant strap picks one of two rotation offsets. Every output is the OR of all pin levels currently routed to it.

Older host software was written for a wiring in which pin n of every slot simply drove line n. The block detects such software by watching configuration-space writes. When software programs a device's interrupt-line register, the value it writes shows which wiring it expects. A three-state sticky detector records the first such decision. It then keeps either the plain pin-to-line mapping or the correct rotated mapping until the next reset. On the second board variant detection is disabled and the rotated mapping always applies.

Top module: `irq_router`

## Requirements
- R1: After a synchronous active-low reset the detector is undecided. On strap value 0 the rotated mapping applies: slot 31 pin 0 drives line 1.
- R2: With strap 0 and the detector not in legacy mode, pin p of slot s drives line (p + s + 2) mod 4. Slot index i of `irq_in` is slot 29+i, and pin p of it is bit 4*i+p.
- R3: With strap 1, pin p of slot s drives line (p + s + 3) mod 4. Configuration writes never change the routing.
- R4: A qualifying write carrying data 27 switches to legacy mode, in which pin p of every slot drives line p. A write qualifies when `cfg_wr` is high, `cfg_addr[7:0]` is 0x3C, the slot number `cfg_addr[15:11]` mod 4 is not 2, strap is 0, and the detector is undecided.
- R5: A qualifying write carrying any other data locks the rotated mapping.
- R6: Writes whose low address byte is not 0x3C have no effect on routing.
- R7: Writes to a slot whose number mod 4 equals 2 (for example slot 30) have no effect on routing.
- R8: Once the detector is in legacy or locked mode, no further write changes the mapping until reset.
- R9: Each line is the OR of the levels routed to it. With all inputs low, all lines are low. No more lines are high than inputs.
- R10: A write changes routing only after the clock edge that samples its strobe, never during the strobe cycle itself.
- R11: Address and data are ignored while `cfg_wr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Single-cycle configuration write strobe |
| cfg_addr | input | ADDR_W (24) | Configuration write address; [15:8] device/function, [7:0] register offset |
| cfg_data | input | DATA_W (8) | Configuration write data, low byte |
| board_alt | input | 1 | Board-variant strap: 0 first variant (detection on), 1 second variant |
| irq_in | input | NUM_SLOTS*4 (12) | Pin levels, bit 4*i+p is pin p of slot 29+i |
| irq_out | output | 4 | System interrupt lines |

## Verification
A detector stuck in or wrongly moved to the wrong state shows at the ports as a rotated line. For example, slot 31 INTA appears on line 0 instead of line 1, or the reverse. This becomes visible in the first cycle after the strobe edge, as soon as any pin is driven. The bench therefore follows each write with a routing probe. It pairs every ignored write with a probe on the same pin before and after, and checks that the output during the strobe cycle still shows the previous mapping.

// File: rtl/irqrt_pkg.sv
// Shared types for the interrupt router.
// Assumes four interrupt pins per slot and four system lines.
package irqrt_pkg;
    localparam int PINS = 4;

    typedef enum logic [1:0] {
        MAP_UNDECIDED = 2'd0,
        MAP_LEGACY    = 2'd1,
        MAP_LOCKED    = 2'd2
    } map_state_t;
endpackage

// File: rtl/irqrt_detect.sv
// Sticky wiring detector. Watches configuration writes to the interrupt-line
// register and decides once, after reset, whether software expects the plain
// pin-to-line wiring. Assumes cfg_wr is a single-cycle strobe and board_alt
// is static while out of reset.
module irqrt_detect
    import irqrt_pkg::*;
#(
    parameter int              ADDR_W      = 24,
    parameter int              DATA_W      = 8,
    parameter int              DEVFN_LSB   = 8,
    parameter logic [7:0]      LINE_OFFSET = 8'h3C,
    parameter logic [DATA_W-1:0] LEGACY_LINE = DATA_W'(27)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              board_alt,
    output map_state_t        state_q
);
    localparam int SLOT_LSB = DEVFN_LSB + 3;

    logic hit_offset;
    logic slot_differs;
    logic qualify;

    // Decode whether the current write can decide the wiring.
    always_comb begin
        hit_offset   = (cfg_addr[7:0] == LINE_OFFSET);
        slot_differs = (cfg_addr[SLOT_LSB+1:SLOT_LSB] != 2'd2);
        qualify      = cfg_wr && hit_offset && slot_differs && !board_alt
                       && (state_q == MAP_UNDECIDED);
    end

    // Record the first qualifying decision; hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MAP_UNDECIDED;
        end else if (qualify) begin
            state_q <= (cfg_data == LEGACY_LINE) ? MAP_LEGACY : MAP_LOCKED;
        end
    end

    assert_reset_undecided_R1: assert property (@(posedge clk)
        !rst_n |=> state_q == MAP_UNDECIDED);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MAP_UNDECIDED) |=> (state_q == $past(state_q)));

    assert_alt_never_decides_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (board_alt && state_q == MAP_UNDECIDED) |=> (state_q == MAP_UNDECIDED));

    assert_idle_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && state_q == MAP_UNDECIDED) |=> (state_q == MAP_UNDECIDED));

    assert_other_data_not_legacy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MAP_UNDECIDED && cfg_data != LEGACY_LINE) |=> (state_q != MAP_LEGACY));
endmodule

// File: rtl/irqrt_swizzle.sv
// Combinational routing network. Each slot pin is steered to one of four
// lines by the legacy identity map or one of two rotations, then the lines
// OR together everything steered onto them. Assumes slot numbers are
// consecutive starting at FIRST_SLOT.
module irqrt_swizzle
    import irqrt_pkg::*;
#(
    parameter int NUM_SLOTS  = 3,
    parameter int FIRST_SLOT = 29
) (
    input  logic [NUM_SLOTS*PINS-1:0] irq_in,
    input  logic                      board_alt,
    input  logic                      legacy,
    output logic [PINS-1:0]           irq_out
);
    localparam int NSRC = NUM_SLOTS * PINS;

    logic [PINS-1:0] route [NSRC];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            localparam int ROT_A = (p + FIRST_SLOT + s + 2) % PINS;
            localparam int ROT_B = (p + FIRST_SLOT + s + 3) % PINS;
            // Pick the one-hot destination line of this slot pin.
            always_comb begin
                if (legacy)
                    route[s*PINS+p] = PINS'(1) << p;
                else if (board_alt)
                    route[s*PINS+p] = PINS'(1) << ROT_B;
                else
                    route[s*PINS+p] = PINS'(1) << ROT_A;
            end
        end
    end

    // Merge all active pins onto their destination lines.
    always_comb begin
        irq_out = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (irq_in[i]) irq_out = irq_out | route[i];
        end
    end
endmodule

// File: rtl/irq_router.sv
// Top of the interrupt router: sticky wiring detector feeding the routing
// network. Assumes board_alt is a static strap and cfg_wr a one-cycle strobe.
module irq_router
    import irqrt_pkg::*;
#(
    parameter int NUM_SLOTS  = 3,
    parameter int FIRST_SLOT = 29,
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [DATA_W-1:0]         cfg_data,
    input  logic                      board_alt,
    input  logic [NUM_SLOTS*PINS-1:0] irq_in,
    output logic [PINS-1:0]           irq_out
);
    map_state_t state_q;
    logic       legacy;

    irqrt_detect #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .board_alt (board_alt),
        .state_q   (state_q)
    );

    // Reduce detector state to the routing select.
    always_comb legacy = (state_q == MAP_LEGACY);

    irqrt_swizzle #(
        .NUM_SLOTS  (NUM_SLOTS),
        .FIRST_SLOT (FIRST_SLOT)
    ) u_swizzle (
        .irq_in    (irq_in),
        .board_alt (board_alt),
        .legacy    (legacy),
        .irq_out   (irq_out)
    );

    assert_quiet_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in == '0) |-> (irq_out == '0));

    assert_no_extra_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out) <= $countones(irq_in));
endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [23:0] cfg_addr = '0;
    logic [7:0]  cfg_data = '0;
    logic        board_alt = 1'b0;
    logic [11:0] irq_in = '0;
    logic [3:0]  irq_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_router dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .board_alt(board_alt), .irq_in(irq_in),
        .irq_out(irq_out)
    );

    // {strap, input mask, expected lines}
    typedef struct packed { logic alt; logic [11:0] mask; logic [3:0] exp; } vec_t;
    localparam vec_t VECS [14] = '{
        '{1'b0, 12'h001, 4'b1000},  // slot29 p0 -> 3
        '{1'b0, 12'h010, 4'b0001},  // slot30 p0 -> 0
        '{1'b0, 12'h100, 4'b0010},  // slot31 p0 -> 1
        '{1'b0, 12'h800, 4'b0001},  // slot31 p3 -> 0
        '{1'b0, 12'h002, 4'b0001},  // slot29 p1 -> 0
        '{1'b0, 12'h011, 4'b1001},
        '{1'b0, 12'h110, 4'b0011},
        '{1'b0, 12'h000, 4'b0000},
        '{1'b1, 12'h001, 4'b0001},  // slot29 p0 -> 0
        '{1'b1, 12'h010, 4'b0010},  // slot30 p0 -> 1
        '{1'b1, 12'h100, 4'b0100},  // slot31 p0 -> 2
        '{1'b1, 12'h200, 4'b1000},  // slot31 p1 -> 3
        '{1'b1, 12'h008, 4'b1000},  // slot29 p3 -> 3
        '{1'b1, 12'hFFF, 4'b1111}
    };

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic probe(input string tag, input logic [11:0] mask, input logic [3:0] exp);
        irq_in = mask;
        #1;
        check(tag, irq_out, exp);
    endtask

    // Strobe one write at a negedge; check routing mid-strobe, then after the edge.
    task automatic cfg_write(input logic strobe, input logic [7:0] devfn,
                             input logic [7:0] off, input logic [7:0] data,
                             input logic [3:0] exp_during);
        @(negedge clk);
        cfg_wr = strobe; cfg_addr = {8'h00, devfn, off}; cfg_data = data;
        irq_in = 12'h100;
        #1;
        check("R10 strobe cycle keeps old routing", irq_out, exp_during);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        probe("R9 reset idle lines", 12'h000, 4'b0000);
        probe("R1 reset rotated slot31 p0", 12'h100, 4'b0010);

        for (int i = 0; i < 14; i++) begin
            board_alt = VECS[i].alt;
            probe(VECS[i].alt ? "R3 second variant map" : "R2 first variant map",
                  VECS[i].mask, VECS[i].exp);
        end

        // R3: strap 1 ignores a legacy-looking write
        board_alt = 1'b1;
        cfg_write(1'b1, 8'hF8, 8'h3C, 8'd27, 4'b0100);
        probe("R3 write ignored on second variant", 12'h100, 4'b0100);
        board_alt = 1'b0;
        probe("R3 still undecided after strap returns", 12'h100, 4'b0010);

        // R6: wrong offset
        cfg_write(1'b1, 8'hF8, 8'h3D, 8'd27, 4'b0010);
        probe("R6 other offset ignored", 12'h100, 4'b0010);
        // R11: no strobe
        cfg_write(1'b0, 8'hF8, 8'h3C, 8'd27, 4'b0010);
        probe("R11 unstrobed write ignored", 12'h100, 4'b0010);
        // R7: slot 30
        cfg_write(1'b1, 8'hF0, 8'h3C, 8'd27, 4'b0010);
        probe("R7 slot30 write ignored", 12'h100, 4'b0010);

        // R4: slot 31 writes 27 -> legacy
        cfg_write(1'b1, 8'hF8, 8'h3C, 8'd27, 4'b0010);
        probe("R4 legacy slot31 p0", 12'h100, 4'b0001);
        probe("R4 legacy slot29 p2", 12'h004, 4'b0100);
        probe("R4 legacy OR of pins", 12'h421, 4'b0111);
        // R8: later write does not leave legacy
        cfg_write(1'b1, 8'hE8, 8'h3C, 8'd5, 4'b0001);
        probe("R8 legacy sticky", 12'h100, 4'b0001);

        // R5: other data locks rotated
        do_reset();
        @(negedge clk);
        probe("R1 reset restores rotation", 12'h100, 4'b0010);
        cfg_write(1'b1, 8'hE8, 8'h3C, 8'd9, 4'b0010);
        probe("R5 locked rotated slot31 p0", 12'h100, 4'b0010);
        cfg_write(1'b1, 8'hF8, 8'h3C, 8'd27, 4'b0010);
        probe("R5 locked ignores later 27 (R8)", 12'h100, 4'b0010);
        probe("R5 locked slot29 p0", 12'h001, 4'b1000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule